// File: doc/BRIEF.md
# Hierarchical Effective Address Generator

This block produces 24-bit word addresses for loads, stores and jumps on a machine with 16-bit words and no byte addressing. A request picks one of four reach levels. Page reach keeps the upper address bits of the current program counter and supplies the bottom eight bits from the instruction. Block reach keeps the program counter's block number and supplies a full 16-bit offset from a general-purpose register. Global reach takes a two-word instruction: the first word carries the block number and the second word carries the 16-bit offset.

An optional fourth level adds a signed 8-bit displacement to the program counter through a full-width adder, so short jumps and accesses can cross page and block boundaries. The result is registered. A one-cycle valid strobe marks each finished address. While a global instruction waits for its second word, the block number is held in a small latch stage.

Top module: `hier_addr_gen`

## Requirements
- R1: During reset and in the first cycle after it, `valid_o` is 0 and `addr_o` is 0.
- R2: A request with `mode_i` = 2'b00 (page) gives `addr_o` = {`pc_i`[23:8], `instr_i`[7:0]}, with `valid_o` = 1 in the cycle after the request.
- R3: A request with `mode_i` = 2'b01 (block) gives `addr_o` = {`pc_i`[23:16], `reg_i`[15:0]}, with `valid_o` = 1 in the cycle after the request.
- R4: A request with `mode_i` = 2'b10 (global) captures `instr_i`[7:0] as the block number and does not raise `valid_o`. The next request then supplies the second word, whatever its `mode_i`. One cycle after that request, `addr_o` = {block number, `instr_i`[15:0]} and `valid_o` = 1.
- R5: Cycles without a request between the two global words keep `valid_o` at 0, and they do not disturb the held block number.
- R6: A request with `mode_i` = 2'b11 (PC-relative) gives `addr_o` = `pc_i` + sign-extended `instr_i`[7:0], modulo 2^24. The result may cross page and block boundaries.
- R7: A PC-relative displacement code of 8'h80 is reserved and adds zero, so `addr_o` = `pc_i`.
- R8: In any cycle without a request, the next cycle has `valid_o` = 0 and `addr_o` keeps its previous value.
- R9: With `PCREL_EN` = 0, a PC-relative request is ignored: `valid_o` stays 0 and `addr_o` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Address request for this cycle |
| mode_i | input | 2 | Reach level: 00 page, 01 block, 10 global, 11 PC-relative |
| instr_i | input | 16 | Current instruction word (first or second word) |
| reg_i | input | 16 | General-purpose register value (block offset) |
| pc_i | input | 24 | Current program counter |
| addr_o | output | 24 | Registered effective address |
| valid_o | output | 1 | One-cycle strobe marking a finished address |

## Verification
The bench builds two copies of the block. Both use the default 24-bit address and 8-bit displacement. One has the PC-relative adder enabled and the other has it disabled, so a single stimulus stream exercises both the adder and its removal. With the full 24-bit width, the bench can reach the wrap at 24'hFFFFFF and the underflow below address zero. It also reaches carries from the displacement into bits 23..8, which page reach cannot produce.

// File: rtl/hag_pkg.sv
package hag_pkg;
    typedef enum logic [1:0] {
        REACH_PAGE   = 2'b00,
        REACH_BLOCK  = 2'b01,
        REACH_GLOBAL = 2'b10,
        REACH_PCREL  = 2'b11
    } reach_e;
endpackage

// File: rtl/hag_pcrel_add.sv
module hag_pcrel_add #(
    parameter int ADDR_W = 24,
    parameter int DISP_W = 8
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [DISP_W-1:0] disp_i,
    output logic [ADDR_W-1:0] sum_o
);
    localparam int EXT_W = ADDR_W - DISP_W;
    localparam logic [DISP_W-1:0] RESERVED = {1'b1, {(DISP_W-1){1'b0}}};

    logic [ADDR_W-1:0] ext;

    always_comb begin
        ext = {{EXT_W{disp_i[DISP_W-1]}}, disp_i};
        if (disp_i == RESERVED) begin
            ext = '0;
        end
        sum_o = base_i + ext;
    end
endmodule

// File: rtl/hag_global_hold.sv
module hag_global_hold #(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             finish_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic             held_o,
    output logic [IDX_W-1:0] idx_o
);
    typedef struct packed {
        logic             held;
        logic [IDX_W-1:0] idx;
    } hold_t;

    hold_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (finish_i) begin
            st_d.held = 1'b0;
        end else if (start_i) begin
            st_d.held = 1'b1;
            st_d.idx  = idx_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign held_o = st_q.held;
    assign idx_o  = st_q.idx;

    // R4: capturing the first word arms the hold stage
    a_r4_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !finish_i) |=> held_o);
    // R4: the second word releases the hold stage
    a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
        finish_i |=> !held_o);
    // R5: idle cycles keep the held index unchanged
    a_r5_keep_idx: assert property (@(posedge clk) disable iff (!rst_n)
        (held_o && !finish_i && !start_i) |=> (held_o && $stable(idx_o)));
endmodule

// File: rtl/hier_addr_gen.sv
module hier_addr_gen
    import hag_pkg::*;
#(
    parameter int ADDR_W   = 24,
    parameter int WORD_W   = 16,
    parameter int PAGE_W   = 8,
    parameter bit PCREL_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [1:0]        mode_i,
    input  logic [WORD_W-1:0] instr_i,
    input  logic [WORD_W-1:0] reg_i,
    input  logic [ADDR_W-1:0] pc_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              valid_o
);
    localparam int IDX_W = ADDR_W - WORD_W;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              valid;
    } out_t;

    out_t out_d, out_q;
    logic start, finish, held;
    logic [IDX_W-1:0] held_idx;
    logic [ADDR_W-1:0] pcrel_sum;
    reach_e reach;

    assign reach = reach_e'(mode_i);

    hag_global_hold #(.IDX_W(IDX_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start),
        .finish_i (finish),
        .idx_i    (instr_i[IDX_W-1:0]),
        .held_o   (held),
        .idx_o    (held_idx)
    );

    generate
        if (PCREL_EN) begin : g_pcrel
            hag_pcrel_add #(.ADDR_W(ADDR_W), .DISP_W(PAGE_W)) u_add (
                .base_i (pc_i),
                .disp_i (instr_i[PAGE_W-1:0]),
                .sum_o  (pcrel_sum)
            );
        end else begin : g_no_pcrel
            assign pcrel_sum = '0;
        end
    endgenerate

    always_comb begin
        out_d       = out_q;
        out_d.valid = 1'b0;
        start       = 1'b0;
        finish      = 1'b0;
        if (req_i) begin
            if (held) begin
                finish      = 1'b1;
                out_d.addr  = {held_idx, instr_i};
                out_d.valid = 1'b1;
            end else begin
                case (reach)
                    REACH_PAGE: begin
                        out_d.addr  = {pc_i[ADDR_W-1:PAGE_W], instr_i[PAGE_W-1:0]};
                        out_d.valid = 1'b1;
                    end
                    REACH_BLOCK: begin
                        out_d.addr  = {pc_i[ADDR_W-1:WORD_W], reg_i};
                        out_d.valid = 1'b1;
                    end
                    REACH_GLOBAL: begin
                        start = 1'b1;
                    end
                    default: begin
                        if (PCREL_EN) begin
                            out_d.addr  = pcrel_sum;
                            out_d.valid = 1'b1;
                        end
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign addr_o  = out_q.addr;
    assign valid_o = out_q.valid;

    // R8: a strobe is only ever the answer to a request
    a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> (!valid_o && $stable(addr_o)));
    // R2: page reach keeps the program counter's page
    a_r2_same_page: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !held && mode_i == 2'b00) |=>
        (valid_o && addr_o[ADDR_W-1:PAGE_W] == $past(pc_i[ADDR_W-1:PAGE_W])));
    // R3: block reach passes the register as offset
    a_r3_reg_offset: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !held && mode_i == 2'b01) |=>
        (valid_o && addr_o[WORD_W-1:0] == $past(reg_i)));
    // R4: first global word never raises the strobe
    a_r4_first_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !held && mode_i == 2'b10) |=> !valid_o);
    // R9: without the adder a PC-relative request is dropped
    a_r9_pcrel_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!PCREL_EN && req_i && !held && mode_i == 2'b11) |=>
        (!valid_o && $stable(addr_o)));
endmodule

// File: tb/hier_addr_gen_tb.sv
module hier_addr_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [1:0]  mode = 2'b00;
    logic [15:0] instr = '0;
    logic [15:0] regv = '0;
    logic [23:0] pc = '0;
    logic [23:0] addr_a, addr_b;
    logic        valid_a, valid_b;
    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    hier_addr_gen u_dut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .mode_i(mode),
        .instr_i(instr), .reg_i(regv), .pc_i(pc),
        .addr_o(addr_a), .valid_o(valid_a)
    );

    hier_addr_gen #(.PCREL_EN(1'b0)) u_nopc (
        .clk(clk), .rst_n(rst_n), .req_i(req), .mode_i(mode),
        .instr_i(instr), .reg_i(regv), .pc_i(pc),
        .addr_o(addr_b), .valid_o(valid_b)
    );

    task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one request cycle, then return at the following negedge
    task automatic issue(input logic [1:0] m, input logic [15:0] w,
                         input logic [15:0] r, input logic [23:0] p);
        @(negedge clk);
        req = 1'b1; mode = m; instr = w; regv = r; pc = p;
        @(negedge clk);
        req = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 valid", {23'd0, valid_a}, 24'd0);
        check("R1 addr", addr_a, 24'd0);
    endtask

    task automatic t_page;
        issue(2'b00, 16'h4A9C, 16'hFFFF, 24'h123456);
        check("R2 valid", {23'd0, valid_a}, 24'd1);
        check("R2 addr", addr_a, 24'h12349C);
        issue(2'b00, 16'h0000, 16'h0000, 24'hFFFFFF);
        check("R2 addr top", addr_a, 24'hFFFF00);
    endtask

    task automatic t_block;
        issue(2'b01, 16'h55AA, 16'hBEEF, 24'hAB1234);
        check("R3 valid", {23'd0, valid_a}, 24'd1);
        check("R3 addr", addr_a, 24'hABBEEF);
    endtask

    task automatic t_global;
        issue(2'b10, 16'h5C7E, 16'h0000, 24'h000000);
        check("R4 first silent", {23'd0, valid_a}, 24'd0);
        issue(2'b01, 16'h1357, 16'hDEAD, 24'h999999);
        check("R4 valid", {23'd0, valid_a}, 24'd1);
        check("R4 addr", addr_a, 24'h7E1357);
    endtask

    task automatic t_global_gap;
        issue(2'b10, 16'hFF03, 16'h0000, 24'h000000);
        for (int i = 0; i < 3; i++) begin
            check("R5 idle", {23'd0, valid_a}, 24'd0);
            @(negedge clk);
        end
        issue(2'b00, 16'hCAFE, 16'h0000, 24'h111111);
        check("R5 valid", {23'd0, valid_a}, 24'd1);
        check("R5 addr", addr_a, 24'h03CAFE);
    endtask

    task automatic t_pcrel;
        issue(2'b11, 16'h0005, 16'h0000, 24'h0100FF);
        check("R6 fwd page cross", addr_a, 24'h010104);
        check("R6 valid", {23'd0, valid_a}, 24'd1);
        issue(2'b11, 16'h00FF, 16'h0000, 24'h010000);
        check("R6 back block cross", addr_a, 24'h00FFFF);
        issue(2'b11, 16'h007F, 16'h0000, 24'hFFFFFE);
        check("R6 wrap top", addr_a, 24'h00007D);
        issue(2'b11, 16'h0081, 16'h0000, 24'h000000);
        check("R6 wrap bottom", addr_a, 24'hFFFF81);
        issue(2'b11, 16'h0080, 16'h0000, 24'h345678);
        check("R7 reserved code", addr_a, 24'h345678);
    endtask

    task automatic t_idle;
        issue(2'b00, 16'h0042, 16'h0000, 24'h2468AC);
        check("R8 setup", addr_a, 24'h246842);
        @(negedge clk);
        check("R8 no strobe", {23'd0, valid_a}, 24'd0);
        check("R8 addr hold", addr_a, 24'h246842);
    endtask

    task automatic t_nopc;
        issue(2'b00, 16'h0011, 16'h0000, 24'h777700);
        check("R9 setup", addr_b, 24'h777711);
        issue(2'b11, 16'h0004, 16'h0000, 24'h777700);
        check("R9 no strobe", {23'd0, valid_b}, 24'd0);
        check("R9 addr hold", addr_b, 24'h777711);
        check("R9 other copy adds", addr_a, 24'h777704);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_page();
        t_block();
        t_global();
        t_global_gap();
        t_pcrel();
        t_idle();
        t_nopc();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule